// File: doc/BRIEF.md
# Digital Carrier Tracking Loop

This block is a sampled phase-locked loop that follows one continuous tone arriving as signed samples at the decimated rate. Each accepted sample is multiplied by the cosine of the oscillator's current phase. The products of the last four samples are averaged, which keeps the slowly varying term and strongly attenuates the double-frequency term. That average is the phase error.

A loop filter with three branches turns the phase error into a frequency correction. The branches are a direct gain, a single accumulator and a double accumulator. The correction, added to a programmable nominal frequency word, advances a 32-bit phase accumulator. When the third gain is zero, the same hardware behaves as a second-order loop. When it is non-zero, the loop is third order.

The cosine magnitudes live outside the block in a quarter-wave table. The block drives the table address and folds the four quadrants itself. The phase error, the frequency correction (the Doppler estimate), the instantaneous frequency word and the phase are all outputs. All gains are runtime inputs.

Top module: `carrier_track_loop`

## Requirements
- R1: After reset, or after a clock edge with `clr` high, `nco_phase`, `doppler`, all three filter accumulators and `err_valid` are zero, and the four-sample averaging window is empty.
- R2: With k = `nco_phase[31:22]`, `lut_addr` equals k[7:0] when k[8] is 0 and the bitwise complement of k[7:0] when k[8] is 1. The cosine applied to a sample is `lut_data` negated when k[9] XOR k[8] is 1, and `lut_data` unchanged otherwise.
- R3: Each sample accepted with `in_valid` high forms the product sample × cosine. After the edge, `phase_err` equals floor(sum of the four most recent products / 4), and `err_valid` goes high on the fourth accepted sample after reset or clear and stays high until the next clear.
- R4: On an update with a valid error e (the average that includes the sample just accepted), the block does the following, with gains in signed Q16: I1 += gain_i·e; I2 += gain_ii·e; I3 += I2 (new value); `doppler` = (gain_p·e + I1 + I3) >> 16, using an arithmetic shift.
- R5: With `gain_ii` = 0 after a clear, the double-accumulator branch stays at zero, so `doppler` depends only on the direct and single-accumulator branches (a second-order loop).
- R6: The filter accumulators clamp at the largest and smallest AW-bit two's-complement values instead of wrapping.
- R7: On each accepted sample, `nco_phase` advances by `nom_freq` + `doppler`, using the value `doppler` takes at that same edge. `nco_freq` always equals `nom_freq` + `doppler`.
- R8: An update happens on every DECIM-th accepted sample (every sample for DECIM = 1). While `in_valid` is low, phase, error, accumulators and `doppler` hold their values.
- R9: The gain inputs are sampled at the update edge only. A gain changed between samples takes effect on the next update.
- R10: The phase accumulator wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of phase, filter and window |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | W | Signed input sample |
| nom_freq | input | 32 | Nominal phase increment per sample |
| gain_p | input | GW | Direct-branch gain, signed Q16 |
| gain_i | input | GW | Single-accumulator gain, signed Q16 |
| gain_ii | input | GW | Double-accumulator gain, signed Q16 |
| lut_addr | output | AB-2 | Quarter-wave cosine table address |
| lut_data | input | LW | Unsigned cosine magnitude from the table |
| phase_err | output | W+LW+1 | Averaged phase error |
| err_valid | output | 1 | Error window filled |
| doppler | output | 32 | Loop filter output (frequency correction) |
| nco_freq | output | 32 | Instantaneous frequency word |
| nco_phase | output | 32 | Phase accumulator |

## Verification
The in-module properties check the following on every cycle:
- the zero state after a clear;
- that `err_valid` cannot drop without a clear;
- that a saturated single accumulator never wraps under a positive increment;
- that a zero third gain leaves the double accumulator untouched;
- that phase and correction hold while no sample arrives.

The exact numerical behaviour can only be shown by the bench's scenarios, which compare against an independent model of the loop. This covers quadrant folding of the table address, the floor average, the three-branch update, phase wrap-around, and the effect of a gain change between samples. Those scenarios cover open-loop tones, closed second- and third-order tracking, and saturation in both directions.

// File: rtl/carrier_track_loop.sv
module carrier_track_loop #(
  parameter int W     = 12,
  parameter int LW    = 12,
  parameter int AB    = 10,
  parameter int GW    = 18,
  parameter int GFRAC = 16,
  parameter int AW    = 48,
  parameter int DECIM = 1
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  in_sample,
  input  logic [31:0]          nom_freq,
  input  logic signed [GW-1:0] gain_p,
  input  logic signed [GW-1:0] gain_i,
  input  logic signed [GW-1:0] gain_ii,
  output logic [AB-3:0]        lut_addr,
  input  logic [LW-1:0]        lut_data,
  output logic signed [W+LW:0] phase_err,
  output logic                 err_valid,
  output logic signed [31:0]   doppler,
  output logic [31:0]          nco_freq,
  output logic [31:0]          nco_phase
);
  localparam int PW  = W + LW + 1;
  localparam int GPW = GW + PW;
  localparam int SW  = ((AW > GPW) ? AW : GPW) + 2;
  localparam int DCW = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic signed [AW-1:0] AHI  = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [SW-1:0] AMAX = SW'(AHI);
  localparam logic signed [SW-1:0] AMIN = ~AMAX;
  localparam logic signed [SW-1:0] FMAX = SW'({1'b0, {31{1'b1}}});
  localparam logic signed [SW-1:0] FMIN = ~FMAX;

  logic signed [PW-1:0] win [4];
  logic [2:0]           fill;
  logic [DCW-1:0]       dcnt;
  logic signed [AW-1:0] a1, b1, b2;

  function automatic logic signed [AW-1:0] sat_a(input logic signed [SW-1:0] x);
    if (x > AMAX) return AHI;
    if (x < AMIN) return ~AHI;
    return AW'(x);
  endfunction

  function automatic logic signed [31:0] sat_f(input logic signed [SW-1:0] x);
    if (x > FMAX) return 32'sh7fffffff;
    if (x < FMIN) return 32'sh80000000;
    return 32'(x);
  endfunction

  logic [AB-1:0] tidx;
  assign tidx     = nco_phase[31 -: AB];
  assign lut_addr = tidx[AB-3:0] ^ {(AB-2){tidx[AB-2]}};

  logic signed [LW:0] cosv;
  assign cosv = (tidx[AB-1] ^ tidx[AB-2]) ? -$signed({1'b0, lut_data})
                                          :  $signed({1'b0, lut_data});

  logic signed [PW-1:0] prod;
  assign prod = in_sample * cosv;

  logic signed [PW+1:0] sum_new, sum_cur;
  assign sum_new = (PW+2)'(prod)   + (PW+2)'(win[0]) + (PW+2)'(win[1]) + (PW+2)'(win[2]);
  assign sum_cur = (PW+2)'(win[0]) + (PW+2)'(win[1]) + (PW+2)'(win[2]) + (PW+2)'(win[3]);

  logic signed [PW-1:0] err_n;
  assign err_n     = PW'(sum_new >>> 2);
  assign phase_err = PW'(sum_cur >>> 2);
  assign err_valid = fill[2];

  logic fire;
  assign fire = in_valid && (dcnt == DCW'(DECIM - 1)) && (fill >= 3'd3);

  logic signed [GPW-1:0] gp_prod, gi_prod, gii_prod;
  assign gp_prod  = gain_p  * err_n;
  assign gi_prod  = gain_i  * err_n;
  assign gii_prod = gain_ii * err_n;

  logic signed [AW-1:0] a1_n, b1_n, b2_n;
  assign a1_n = sat_a(SW'(a1) + SW'(gi_prod));
  assign b1_n = sat_a(SW'(b1) + SW'(gii_prod));
  assign b2_n = sat_a(SW'(b2) + SW'(b1_n));

  logic signed [SW-1:0] fsum;
  logic signed [31:0]   f_n, f_sel;
  assign fsum  = SW'(gp_prod) + SW'(a1_n) + SW'(b2_n);
  assign f_n   = sat_f(fsum >>> GFRAC);
  assign f_sel = fire ? f_n : doppler;

  assign nco_freq = nom_freq + $unsigned(doppler);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) win[i] <= '0;
      fill <= '0; dcnt <= '0;
      a1 <= '0; b1 <= '0; b2 <= '0;
      doppler <= '0; nco_phase <= '0;
    end else if (clr) begin
      for (int i = 0; i < 4; i++) win[i] <= '0;
      fill <= '0; dcnt <= '0;
      a1 <= '0; b1 <= '0; b2 <= '0;
      doppler <= '0; nco_phase <= '0;
    end else if (in_valid) begin
      win[0] <= prod;
      for (int i = 1; i < 4; i++) win[i] <= win[i-1];
      fill      <= fill[2] ? fill : fill + 3'd1;
      dcnt      <= (dcnt == DCW'(DECIM - 1)) ? '0 : dcnt + DCW'(1);
      nco_phase <= nco_phase + nom_freq + $unsigned(f_sel);
      if (fire) begin
        a1 <= a1_n; b1 <= b1_n; b2 <= b2_n;
        doppler <= f_n;
      end
    end
  end

  // R1: clear empties every piece of state
  a_r1_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (nco_phase == '0 && doppler == '0 && a1 == '0 && b1 == '0 && b2 == '0 && !err_valid));

  // R3: error valid stays up until a clear
  a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !clr) |=> err_valid);

  // R6: a saturated accumulator does not wrap on a positive step
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr && a1 == AHI && gi_prod >= 0) |=> a1 == AHI);

  // R5: zero third gain leaves the double accumulator idle
  a_r5_second_order: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr && gain_ii == '0 && b1 == '0) |=> (b1 == '0 && $stable(b2)));

  // R8: nothing moves without a sample
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> ($stable(nco_phase) && $stable(doppler) && $stable(phase_err)));
endmodule

// File: tb/sim_carrier_track_loop.sv
module sim_carrier_track_loop;
  localparam int W = 12, LW = 12, AB = 10, GW = 18, AW = 36, DECIM = 1;
  localparam int PW = W + LW + 1;

  logic clk = 0, rst_n = 0, clr = 0, in_valid = 0;
  logic signed [W-1:0]  in_sample = '0;
  logic [31:0]          nom_freq = '0;
  logic signed [GW-1:0] gain_p = '0, gain_i = '0, gain_ii = '0;
  logic [AB-3:0]        lut_addr;
  logic [LW-1:0]        lut_data;
  logic signed [PW-1:0] phase_err;
  logic                 err_valid;
  logic signed [31:0]   doppler;
  logic [31:0]          nco_freq, nco_phase;

  always #5 clk = ~clk;

  carrier_track_loop #(.W(W), .LW(LW), .AB(AB), .GW(GW), .AW(AW), .DECIM(DECIM)) u0 (
    .clk, .rst_n, .clr, .in_valid, .in_sample, .nom_freq, .gain_p, .gain_i, .gain_ii,
    .lut_addr, .lut_data, .phase_err, .err_valid, .doppler, .nco_freq, .nco_phase);

  function automatic int tbl(input int a);
    real x;
    x = (2.0**LW - 1.0) * $cos(2.0 * 3.14159265358979 * (a + 0.5) / (2.0**AB));
    return $rtoi(x + 0.5);
  endfunction
  assign lut_data = LW'(tbl(int'(lut_addr)));

  typedef struct {
    string req; logic [31:0] ph; longint dop; longint err; bit ev; int addr;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  longint m_a1, m_b1, m_b2, m_f, m_w[4];
  logic [31:0] m_ph;
  int m_fill, m_dc;

  function automatic longint sat(input longint x, input int bits);
    longint hi, lo;
    hi = (64'sd1 <<< (bits - 1)) - 1;
    lo = -hi - 1;
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  function automatic int addr_of(input logic [31:0] ph);
    logic [AB-1:0] k;
    k = ph[31 -: AB];
    return int'(k[AB-3:0] ^ {(AB-2){k[AB-2]}});
  endfunction

  task automatic model_clear();
    m_a1 = 0; m_b1 = 0; m_b2 = 0; m_f = 0; m_ph = '0; m_fill = 0; m_dc = 0;
    for (int i = 0; i < 4; i++) m_w[i] = 0;
  endtask

  task automatic send(input int s, input string req);
    logic [AB-1:0] k;
    longint cosv, prod, e, sum;
    exp_t x;
    bit upd;
    @(negedge clk);
    in_sample = W'(s);
    in_valid  = 1;
    k = m_ph[31 -: AB];
    cosv = tbl(addr_of(m_ph));
    if (k[AB-1] ^ k[AB-2]) cosv = -cosv;
    prod = longint'(s) * cosv;
    sum = prod + m_w[0] + m_w[1] + m_w[2];
    e = sum >>> 2;
    upd = (m_dc == DECIM - 1) && (m_fill >= 3);
    m_dc = (m_dc == DECIM - 1) ? 0 : m_dc + 1;
    for (int i = 3; i > 0; i--) m_w[i] = m_w[i-1];
    m_w[0] = prod;
    if (m_fill < 4) m_fill++;
    if (upd) begin
      m_a1 = sat(m_a1 + longint'(gain_i) * e, AW);
      m_b1 = sat(m_b1 + longint'(gain_ii) * e, AW);
      m_b2 = sat(m_b2 + m_b1, AW);
      m_f  = sat((longint'(gain_p) * e + m_a1 + m_b2) >>> 16, 32);
    end
    m_ph = m_ph + nom_freq + 32'(m_f);
    x.req = req; x.ph = m_ph; x.dop = m_f; x.ev = (m_fill == 4);
    x.err = (m_w[0] + m_w[1] + m_w[2] + m_w[3]) >>> 2;
    x.addr = addr_of(m_ph);
    q.push_back(x);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  bit took = 0;
  always @(posedge clk) took <= in_valid && !clr && rst_n;

  always @(negedge clk) begin
    if (took) begin
      if (q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: result with no expected item, actual 1 expected 0");
      end else begin
        exp_t x;
        x = q.pop_front();
        chk(x.req, "R7 nco_phase", longint'(nco_phase), longint'(x.ph));
        chk(x.req, "R4 doppler", longint'(doppler), x.dop);
        chk(x.req, "R7 nco_freq", longint'(nco_freq), longint'(32'(nom_freq + 32'(x.dop))));
        chk(x.req, "R2 lut_addr", longint'(lut_addr), longint'(x.addr));
        chk(x.req, "R3 err_valid", longint'(err_valid), longint'(x.ev));
        if (x.ev) chk(x.req, "R3 phase_err", longint'(phase_err), x.err);
      end
    end
  end

  task automatic check_state(input string req);
    chk(req, "nco_phase", longint'(nco_phase), longint'(m_ph));
    chk(req, "doppler", longint'(doppler), m_f);
    chk(req, "err_valid", longint'(err_valid), longint'(m_fill == 4));
  endtask

  task automatic do_clear();
    @(negedge clk);
    in_valid = 0; clr = 1;
    @(negedge clk);
    clr = 0;
    model_clear();
    check_state("R1 clear");
  endtask

  task automatic tone(input int n, input real amp, input real cyc, input real ph0, input string req);
    for (int i = 0; i < n; i++)
      send($rtoi(amp * $cos(2.0 * 3.14159265358979 * cyc * i + ph0)), req);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 reset");
    chk("R1 reset", "lut_addr", longint'(lut_addr), 0);

    // R2 R3 R7: open loop, phase steps through all quadrants
    nom_freq = 32'h1000_0000;
    for (int i = 0; i < 20; i++) send((i % 2 == 0) ? 1000 : -700, "R2 R3 open loop");
    idle(3);
    check_state("R8 idle hold");

    // R10: large step wraps the phase accumulator
    nom_freq = 32'hF123_4567;
    for (int i = 0; i < 10; i++) send(1500 - 300 * i, "R10 wrap");
    idle(2);

    // R5: second-order closed loop
    do_clear();
    nom_freq = 32'h0800_0000; gain_p = 18'sd16384; gain_i = 18'sd256; gain_ii = '0;
    tone(60, 1500.0, 0.0315, 0.4, "R5 second order");
    idle(2);

    // R4: third-order closed loop
    do_clear();
    gain_ii = 18'sd16;
    tone(60, 1800.0, 0.0318, 1.1, "R4 third order");

    // R9: gain change between samples takes effect on the next update
    idle(3);
    gain_p = -18'sd8192; gain_i = 18'sd1024; gain_ii = -18'sd32;
    tone(20, 1800.0, 0.0318, 2.0, "R9 gain change");
    idle(2);

    // R6: positive then negative saturation of the accumulators
    do_clear();
    nom_freq = '0; gain_p = '0; gain_i = 18'sd131071; gain_ii = 18'sd131071;
    for (int i = 0; i < 12; i++) send(2000, "R6 positive saturation");
    do_clear();
    for (int i = 0; i < 12; i++) send(-2000, "R6 negative saturation");
    idle(2);

    // R8: DECIM=1 updates on every sample, checked after a mid-run clear
    do_clear();
    gain_p = 18'sd4096; gain_i = 18'sd64; gain_ii = '0; nom_freq = 32'h2000_0000;
    tone(16, 900.0, 0.12, 0.0, "R8 update every sample");
    idle(2);
    chk("R3 drained", "queue", longint'(q.size()), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule